// File: doc/BRIEF.md
# Watermark-Driven Audio Sample FIFO Bridge

This block is a memory-mapped transmit queue placed between a bus master (a processor or a DMA engine) that writes 24-bit audio samples and a downstream audio link that consumes them one per handshake. Writes to the sample data register push the low 24 bits of the bus word into a 32-entry FIFO. The FIFO drains through a valid/ready stream.

Two programmable watermarks control a DMA request line with hysteresis. The request rises when the fill level falls to the low watermark or below. It falls once the level climbs above the high watermark. The same two comparisons set sticky watermark interrupt bits. A write into a full queue sets a sticky overflow bit. Raw status, a mask register and a masked view feed a single interrupt line. Clearing the module enable empties the queue and stops all requests. The block uses one clock domain. Its asynchronous active-low reset is released synchronously inside the block.

Top module: `aud_sample_bridge`

## Requirements
- R1: After reset every register reads zero, and `dma_req`, `irq` and `smp_valid` are low.
- R2: Register offsets: 0x00 control (bit 0 module enable); 0x04 extended control (bit 0 DMA enable, low watermark in bits 20:16, high watermark in bits 28:24); 0x08 sample data (write-only, reads zero); 0x0C status; 0x10 raw interrupt status; 0x14 masked interrupt status; 0x18 interrupt mask. Control, extended control and mask read back what was written in these fields.
- R3: While enabled, each write to 0x08 queues bits 23:0 of the write. Samples leave in write order on `smp_data` while `smp_valid` is high, and one sample is removed for each cycle in which `smp_valid` and `smp_ready` are both high. The queue holds 32 samples.
- R4: Status register bits 5:0 give the current number of queued samples (0 to 32).
- R5: A data write that arrives while 32 samples are queued is dropped, even when a sample leaves in the same cycle. The drop sets raw interrupt bit 0 (overflow), and that bit stays set until it is cleared.
- R6: When module enable and DMA enable are both set and the fill level is at or below the low watermark, `dma_req` is high on the next cycle.
- R7: `dma_req` goes low on the cycle after the fill level exceeds the high watermark. Between the two watermarks it keeps its previous value.
- R8: `dma_req` is low on the cycle after module enable or DMA enable is clear.
- R9: While the module is enabled, raw bit 1 is set on the cycle after the fill level is at or below the low watermark, and raw bit 2 is set on the cycle after the level exceeds the high watermark. No raw bit is set by the watermarks while the module is disabled.
- R10: Writing a 1 to a raw bit position at 0x10 or at 0x14 clears that raw bit. If the bit's set condition holds in the same cycle, the set wins.
- R11: The masked status register equals raw status AND the mask register (bit 0 overflow, bit 1 low watermark, bit 2 high watermark). `irq` is high exactly when any masked bit is set.
- R12: While module enable is clear the queue is emptied, data writes are discarded, and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| smp_valid | output | 1 | A queued sample is available |
| smp_ready | input | 1 | Consumer takes the sample this cycle |
| smp_data | output | 24 | Oldest queued sample |
| dma_req | output | 1 | Request for more samples |
| irq | output | 1 | OR of masked interrupt status |

## Verification
The hardest state to reach from the ports is the overflow corner. The queue must be full, which needs 32 accepted writes. A 33rd write must then be lost without disturbing the order of the 32 samples already held, and the dropped value must never appear on the output. The stimulus starts from a partly drained queue of known contents. It tops the queue up to exactly 32 samples, writes one marked value, and then drains all 32 entries, checking each value in order. The hysteresis band is reached in a similar way: the bench overshoots the high watermark and then pops one sample at a time down to the low watermark.

// File: rtl/asb_pkg.sv
package asb_pkg;
  localparam int ADDR_W = 5;
  localparam int IRQ_N  = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_XCTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h18;

  // interrupt bit positions, shared by raw, masked and mask registers
  localparam int IRQ_OVF  = 0;
  localparam int IRQ_LOW  = 1;
  localparam int IRQ_HIGH = 2;

  // watermark field positions in extended control
  localparam int LWM_LSB = 16;
  localparam int HWM_LSB = 24;
endpackage

// File: rtl/asb_regs.sv
module asb_regs
  import asb_pkg::*;
#(
  parameter int WM_W  = 5,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CNT_W-1:0]  fill,
  input  logic [IRQ_N-1:0]  raw,
  output logic              en,
  output logic              dma_en,
  output logic [WM_W-1:0]   lwm,
  output logic [WM_W-1:0]   hwm,
  output logic [IRQ_N-1:0]  mask,
  output logic [IRQ_N-1:0]  w1c,
  output logic              push,
  output logic [31:0]       rdata
);
  logic             wr_any;
  logic             ctrl_we, xctrl_we, mask_we;
  logic             en_d, dma_en_d;
  logic [WM_W-1:0]  lwm_d, hwm_d;
  logic [IRQ_N-1:0] mask_d;

  assign wr_any   = bus_sel && bus_wr;
  assign ctrl_we  = wr_any && (bus_addr == OFS_CTRL);
  assign xctrl_we = wr_any && (bus_addr == OFS_XCTRL);
  assign mask_we  = wr_any && (bus_addr == OFS_MASK);
  assign push     = wr_any && (bus_addr == OFS_DATA);
  assign w1c      = (wr_any && ((bus_addr == OFS_RAW) || (bus_addr == OFS_MSKD)))
                    ? bus_wdata[IRQ_N-1:0] : '0;

  // next-state values
  always_comb begin
    en_d     = bus_wdata[0];
    dma_en_d = bus_wdata[0];
    lwm_d    = bus_wdata[LWM_LSB +: WM_W];
    hwm_d    = bus_wdata[HWM_LSB +: WM_W];
    mask_d   = bus_wdata[IRQ_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      dma_en <= 1'b0;
      lwm    <= '0;
      hwm    <= '0;
      mask   <= '0;
    end else begin
      if (ctrl_we) en <= en_d;
      if (xctrl_we) begin
        dma_en <= dma_en_d;
        lwm    <= lwm_d;
        hwm    <= hwm_d;
      end
      if (mask_we) mask <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:  rdata[0] = en;
      OFS_XCTRL: begin
        rdata[0]                 = dma_en;
        rdata[LWM_LSB +: WM_W]   = lwm;
        rdata[HWM_LSB +: WM_W]   = hwm;
      end
      OFS_STAT:  rdata[CNT_W-1:0] = fill;
      OFS_RAW:   rdata[IRQ_N-1:0] = raw;
      OFS_MSKD:  rdata[IRQ_N-1:0] = raw & mask;
      OFS_MASK:  rdata[IRQ_N-1:0] = mask;
      default:   rdata = '0;
    endcase
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[31:HWM_LSB+WM_W],
                               bus_wdata[HWM_LSB-1:LWM_LSB+WM_W],
                               bus_wdata[LWM_LSB-1:IRQ_N]};

  // a write to the control register lands on the next cycle
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (en == $past(bus_wdata[0])));
endmodule

// File: rtl/asb_fifo.sv
module asb_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DW-1:0]     wdata,
  input  logic              ready,
  output logic              valid,
  output logic [DW-1:0]     rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              ovf_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             full, push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign valid   = (count != '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = valid && ready && !flush;
  assign ovf_evt = push && full && !flush;
  assign rdata   = mem[rd_ptr];

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop_ok)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      if (push_ok && !pop_ok)      count_d = count + CNT_W'(1);
      else if (pop_ok && !push_ok) count_d = count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush && !(valid && ready)) |=> (count == CNT_W'(DEPTH)));
  assert_flush_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/asb_dreq.sv
module asb_dreq #(
  parameter int WM_W  = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dma_en,
  input  logic [CNT_W-1:0] fill,
  input  logic [WM_W-1:0]  lwm,
  input  logic [WM_W-1:0]  hwm,
  output logic             dreq
);
  logic dreq_d, at_low, above_high, active;

  assign active     = en && dma_en;
  assign at_low     = fill <= CNT_W'(lwm);
  assign above_high = fill >  CNT_W'(hwm);

  always_comb begin
    dreq_d = dreq;
    if (!active)         dreq_d = 1'b0;
    else if (at_low)     dreq_d = 1'b1;
    else if (above_high) dreq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq <= 1'b0;
    else        dreq <= dreq_d;
  end

  assert_dreq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_en && (fill <= CNT_W'(lwm))) |=> dreq);
  assert_dreq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill > CNT_W'(hwm)) && !(fill <= CNT_W'(lwm))) |=> !dreq);
  assert_dreq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && dma_en) |=> !dreq);
endmodule

// File: rtl/asb_irq.sv
module asb_irq
  import asb_pkg::*;
#(
  parameter int WM_W  = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] fill,
  input  logic [WM_W-1:0]  lwm,
  input  logic [WM_W-1:0]  hwm,
  input  logic             ovf_evt,
  input  logic [IRQ_N-1:0] w1c,
  input  logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] raw,
  output logic             irq
);
  logic [IRQ_N-1:0] set_ev, raw_d;

  always_comb begin
    set_ev           = '0;
    set_ev[IRQ_OVF]  = ovf_evt;
    set_ev[IRQ_LOW]  = en && (fill <= CNT_W'(lwm));
    set_ev[IRQ_HIGH] = en && (fill >  CNT_W'(hwm));
    raw_d            = (raw & ~w1c) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_d;
  end

  assign irq = |(raw & mask);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> raw[IRQ_OVF]);

  for (genvar b = 0; b < IRQ_N; b++) begin : g_hold
    assert_raw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[b] && !w1c[b]) |=> raw[b]);
  end

  assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !raw[IRQ_LOW] && !raw[IRQ_HIGH]) |=> (!raw[IRQ_LOW] && !raw[IRQ_HIGH]));
endmodule

// File: rtl/aud_sample_bridge.sv
module aud_sample_bridge
  import asb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DW-1:0]     smp_data,
  output logic              dma_req,
  output logic              irq
);
  localparam int WM_W  = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             en, dma_en, push, ovf_evt;
  logic [WM_W-1:0]  lwm, hwm;
  logic [IRQ_N-1:0] mask, w1c, raw;
  logic [CNT_W-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  asb_regs #(.WM_W(WM_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fill(fill), .raw(raw),
    .en(en), .dma_en(dma_en), .lwm(lwm), .hwm(hwm), .mask(mask),
    .w1c(w1c), .push(push), .rdata(bus_rdata)
  );

  asb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush(!en), .push(push),
    .wdata(bus_wdata[DW-1:0]), .ready(smp_ready), .valid(smp_valid),
    .rdata(smp_data), .count(fill), .ovf_evt(ovf_evt)
  );

  asb_dreq #(.WM_W(WM_W), .CNT_W(CNT_W)) u_dreq (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .dma_en(dma_en), .fill(fill),
    .lwm(lwm), .hwm(hwm), .dreq(dma_req)
  );

  asb_irq #(.WM_W(WM_W), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .fill(fill), .lwm(lwm),
    .hwm(hwm), .ovf_evt(ovf_evt), .w1c(w1c), .mask(mask), .raw(raw),
    .irq(irq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (!dma_req && !irq && !smp_valid));
endmodule

// File: tb/sim_aud_sample_bridge.sv
module sim_aud_sample_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_valid, smp_ready = 1'b0, dma_req, irq;
  logic [23:0] smp_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  aud_sample_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .dma_req(dma_req), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pop_one(input string rq, input logic [23:0] exp);
    @(negedge clk);
    chk({rq, " valid"}, {31'b0, smp_valid}, 32'd1);
    chk({rq, " data"}, {8'b0, smp_data}, {8'b0, exp});
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  function automatic logic [31:0] smp(input int i);
    return 32'hA5F0_0000 + i;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(5'(a*4), v);
      chk("R1 reg read", v, 32'h0);
    end
    chk("R1 dma_req", {31'b0, dma_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 smp_valid", {31'b0, smp_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h04, 32'h0804_0000);
    rd(5'h04, v); chk("R2 xctrl readback", v, 32'h0804_0000);
    wr(5'h00, 32'h1);
    rd(5'h00, v); chk("R2 ctrl readback", v, 32'h1);
    settle();
    chk("R8 dreq without DMA enable", {31'b0, dma_req}, 0);
    rd(5'h10, v); chk("R9 low watermark raw", v, 32'h2);
    rd(5'h14, v); chk("R11 masked with zero mask", v, 32'h0);
    chk("R11 irq with zero mask", {31'b0, irq}, 0);
    rd(5'h08, v); chk("R2 data reads zero", v, 32'h0);
  endtask

  task automatic t_dreq();
    logic [31:0] v;
    wr(5'h04, 32'h0804_0001);
    settle();
    chk("R6 dreq rises at empty", {31'b0, dma_req}, 1);
    for (int i = 1; i <= 8; i++) begin
      wr(5'h08, smp(i));
      settle();
      chk("R7 dreq held up to high watermark", {31'b0, dma_req}, 1);
    end
    wr(5'h08, smp(9));
    settle();
    chk("R7 dreq falls above high watermark", {31'b0, dma_req}, 0);
    rd(5'h0C, v); chk("R4 fill count nine", v, 32'd9);
    rd(5'h10, v); chk("R9 high watermark raw", v, 32'h6);
    wr(5'h10, 32'h2);
    rd(5'h10, v); chk("R10 clear low bit via raw", v, 32'h4);
    for (int i = 1; i <= 4; i++) pop_one("R3 order", 24'hF00000 + 24'(i));
    settle();
    chk("R7 dreq holds inside band", {31'b0, dma_req}, 0);
    rd(5'h0C, v); chk("R4 fill count five", v, 32'd5);
    pop_one("R3 order", 24'hF00005);
    settle();
    chk("R6 dreq rises at low watermark", {31'b0, dma_req}, 1);
    wr(5'h18, 32'h4);
    rd(5'h18, v); chk("R2 mask readback", v, 32'h4);
    rd(5'h14, v); chk("R11 masked view", v, 32'h4);
    chk("R11 irq from high bit", {31'b0, irq}, 1);
    wr(5'h14, 32'h4);
    rd(5'h10, v); chk("R10 clear via masked register", v, 32'h2);
    chk("R11 irq after clear", {31'b0, irq}, 0);
    wr(5'h10, 32'h2);
    rd(5'h10, v); chk("R10 set wins over clear", v, 32'h2);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    wr(5'h18, 32'h1);
    for (int i = 10; i <= 37; i++) wr(5'h08, smp(i));
    rd(5'h0C, v); chk("R3 queue holds 32", v, 32'd32);
    rd(5'h10, v); chk("R5 no overflow yet", v & 32'h1, 32'h0);
    wr(5'h08, 32'hA5AB_CDEF);
    rd(5'h0C, v); chk("R5 count stays 32", v, 32'd32);
    rd(5'h10, v); chk("R5 overflow raw bit", v & 32'h1, 32'h1);
    chk("R11 irq from overflow", {31'b0, irq}, 1);
    for (int i = 6; i <= 37; i++) pop_one("R5 drain order", 24'hF00000 + 24'(i));
    settle();
    chk("R5 dropped sample absent", {31'b0, smp_valid}, 0);
    rd(5'h10, v); chk("R5 overflow sticky", v & 32'h1, 32'h1);
    wr(5'h10, 32'h1);
    rd(5'h10, v); chk("R10 overflow cleared", v & 32'h1, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) wr(5'h08, smp(40 + i));
    rd(5'h0C, v); chk("R4 fill count three", v, 32'd3);
    wr(5'h00, 32'h0);
    settle();
    rd(5'h0C, v); chk("R12 flush on disable", v, 32'd0);
    chk("R12 valid after flush", {31'b0, smp_valid}, 0);
    chk("R8 dreq after disable", {31'b0, dma_req}, 0);
    wr(5'h10, 32'h7);
    settle();
    rd(5'h10, v); chk("R9 no watermark bits while disabled", v, 32'h0);
    wr(5'h08, smp(50));
    settle();
    rd(5'h0C, v); chk("R12 write ignored while disabled", v, 32'd0);
    rd(5'h10, v); chk("R12 no overflow while disabled", v, 32'h0);
    chk("R12 irq quiet", {31'b0, irq}, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_dreq();
    t_ovf();
    t_flush();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog (R1-R12 run): actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule